// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel data buses, called A and B, and moves data across in either direction. Each direction has its own storage register with its own capture clock. A rising edge on the A-to-B capture clock stores the current A input. A rising edge on the B-to-A capture clock stores the current B input. Each side's output multiplexer passes one of two values: the live data from the opposite bus, or the value held in that direction's register.

One shared active-low enable and a direction input decide which side, if any, is driven. Each bus is modelled as three separate signals: an input, a data output and an output enable. The surrounding pad logic turns these into a real bidirectional pin. The data outputs always show what the multiplexer selects, whether or not the enable is asserted. A register can therefore be loaded while the outputs are isolated and its contents driven onto a bus later.

Top module: `bus_xcvr_reg`

## Requirements
- R1: An asynchronous active-low reset clears both storage registers to zero. While the stored source is selected, both data outputs then read zero.
- R2: The A-to-B register loads `a_in` on each rising edge of `cap_ab_clk` and holds that value between edges.
- R3: The B-to-A register loads `b_in` on each rising edge of `cap_ba_clk` and holds that value between edges.
- R4: With `sel_ab_stored` = 0, `b_out` equals `a_in` at all times. With `sel_ab_stored` = 1, `b_out` equals the A-to-B register.
- R5: With `sel_ba_stored` = 0, `a_out` equals `b_in` at all times. With `sel_ba_stored` = 1, `a_out` equals the B-to-A register.
- R6: While `oe_n` = 1, both `a_oe` and `b_oe` are 0 (isolation).
- R7: While `oe_n` = 0, `dir_a2b` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `dir_a2b` = 0 gives `a_oe` = 1 and `b_oe` = 0.
- R8: `a_oe` and `b_oe` are never 1 together.
- R9: A capture edge on one direction leaves the other register unchanged. Captures work the same whatever the values of `oe_n` and `dir_a2b`. In particular, data on the undriven bus can be stored in either register or in both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| cap_ab_clk | input | 1 | Rising edge stores `a_in` in the A-to-B register |
| cap_ba_clk | input | 1 | Rising edge stores `b_in` in the B-to-A register |
| sel_ab_stored | input | 1 | 0: `b_out` carries live A data; 1: stored A-to-B value |
| sel_ba_stored | input | 1 | 0: `a_out` carries live B data; 1: stored B-to-A value |
| oe_n | input | 1 | Active-low output enable shared by both sides |
| dir_a2b | input | 1 | 1: drive bus B; 0: drive bus A |
| a_in | input | WIDTH | Data received from bus A |
| a_out | output | WIDTH | Data to present on bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | WIDTH | Data received from bus B |
| b_out | output | WIDTH | Data to present on bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The bench runs each direction once with the live source and once with the stored source. Between those runs the data on the opposite bus changes, so a multiplexer stuck on one source shows a mismatch. Captures on each clock are issued one at a time and also together, using different bit patterns on each bus. This shows whether the registers are swapped, share a clock, or fail to load during isolation. The enable stimulus covers all three states of enable and direction, which separates a direction inversion from a fault in the enable gating. A reset applied mid-run with non-zero stored data confirms that the reset works asynchronously.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } src_e;

   typedef enum logic [1:0] {
      DRV_NONE = 2'b00,
      DRV_A    = 2'b01,
      DRV_B    = 2'b10
   } drive_e;

   localparam int unsigned MIN_WIDTH = 1;
   localparam int unsigned MAX_WIDTH = 1024;
endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
   parameter int unsigned WIDTH   = 8,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      if (WIDTH < 1) $error("xcvr_capture_reg: WIDTH must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
   end
endmodule

// File: rtl/xcvr_out_mux.sv
module xcvr_out_mux
   import xcvr_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  src_e             src,
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   output logic [WIDTH-1:0] y
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign y[i] = (src == SRC_STORED) ? stored[i] : live[i];
   end
endmodule

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
   import xcvr_pkg::*;
(
   input  logic oe_n,
   input  logic dir_a2b,
   output logic a_oe,
   output logic b_oe
);
   drive_e drv;

   always_comb begin
      if (oe_n)         drv = DRV_NONE;
      else if (dir_a2b) drv = DRV_B;
      else              drv = DRV_A;
   end

   assign a_oe = (drv == DRV_A);
   assign b_oe = (drv == DRV_B);
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
   import xcvr_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             rst_n,
   input  logic             cap_ab_clk,
   input  logic             cap_ba_clk,
   input  logic             sel_ab_stored,
   input  logic             sel_ba_stored,
   input  logic             oe_n,
   input  logic             dir_a2b,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe
);
   initial begin
      if (WIDTH < MIN_WIDTH || WIDTH > MAX_WIDTH)
         $error("bus_xcvr_reg: WIDTH out of range");
   end

   logic [WIDTH-1:0] store_ab;
   logic [WIDTH-1:0] store_ba;

   xcvr_capture_reg #(.WIDTH(WIDTH), .RST_VAL('0)) u_reg_ab (
      .clk   (cap_ab_clk),
      .rst_n (rst_n),
      .d     (a_in),
      .q     (store_ab)
   );

   xcvr_capture_reg #(.WIDTH(WIDTH), .RST_VAL('0)) u_reg_ba (
      .clk   (cap_ba_clk),
      .rst_n (rst_n),
      .d     (b_in),
      .q     (store_ba)
   );

   xcvr_out_mux #(.WIDTH(WIDTH)) u_mux_b (
      .src    (src_e'(sel_ab_stored)),
      .live   (a_in),
      .stored (store_ab),
      .y      (b_out)
   );

   xcvr_out_mux #(.WIDTH(WIDTH)) u_mux_a (
      .src    (src_e'(sel_ba_stored)),
      .live   (b_in),
      .stored (store_ba),
      .y      (a_out)
   );

   xcvr_dir_ctrl u_dir (
      .oe_n    (oe_n),
      .dir_a2b (dir_a2b),
      .a_oe    (a_oe),
      .b_oe    (b_oe)
   );
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             rst_n,
   input logic             cap_ab_clk,
   input logic             cap_ba_clk,
   input logic             sel_ab_stored,
   input logic             sel_ba_stored,
   input logic             oe_n,
   input logic             dir_a2b,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] a_out,
   input logic             a_oe,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] b_out,
   input logic             b_oe
);
   // R4
   live_ab_chk: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
      !sel_ab_stored |-> (b_out == a_in));

   // R5
   live_ba_chk: assert property (@(posedge cap_ba_clk) disable iff (!rst_n)
      !sel_ba_stored |-> (a_out == b_in));

   // R6
   isolate_chk: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
      oe_n |-> (!a_oe && !b_oe));

   // R7
   dir_sel_chk: assert property (@(posedge cap_ba_clk) disable iff (!rst_n)
      !oe_n |-> (b_oe == dir_a2b) && (a_oe != dir_a2b));

   // R8
   one_driver_chk: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
      !(a_oe && b_oe));

   // R8
   one_driver_ba_chk: assert property (@(posedge cap_ba_clk) disable iff (!rst_n)
      !(a_oe && b_oe));
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH)) u_chk (
   .rst_n         (rst_n),
   .cap_ab_clk    (cap_ab_clk),
   .cap_ba_clk    (cap_ba_clk),
   .sel_ab_stored (sel_ab_stored),
   .sel_ba_stored (sel_ba_stored),
   .oe_n          (oe_n),
   .dir_a2b       (dir_a2b),
   .a_in          (a_in),
   .a_out         (a_out),
   .a_oe          (a_oe),
   .b_in          (b_in),
   .b_out         (b_out),
   .b_oe          (b_oe)
);

// File: tb/bus_xcvr_reg_tb.sv
module bus_xcvr_reg_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;
   localparam int NVEC = 8;
   localparam int WATCHDOG = 5000;

   typedef struct packed {
      logic         oe_n;
      logic         dir;
      logic         sab;
      logic         sba;
      logic         cap_ab;
      logic         cap_ba;
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic         x_aoe;
      logic         x_boe;
      logic [W-1:0] x_aout;
      logic [W-1:0] x_bout;
   } vec_t;

   // Fields: oe_n dir sab sba cap_ab cap_ba a b | exp a_oe b_oe a_out b_out
   localparam vec_t VECS [NVEC] = '{
      '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,8'h11,8'h22, 1'b0,1'b0,8'h00,8'h00}, // R1 R6
      '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,8'h3C,8'h5A, 1'b0,1'b0,8'h5A,8'h3C}, // R9 R2 R3
      '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,8'h77,8'h99, 1'b0,1'b1,8'h5A,8'h77}, // R4 R5 R7
      '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h12,8'h34, 1'b1,1'b0,8'h34,8'h3C}, // R4 R5 R7
      '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,8'hC3,8'hE1, 1'b0,1'b1,8'h5A,8'hC3}, // R2 R9
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,8'h0F,8'hF0, 1'b1,1'b0,8'hF0,8'hC3}, // R3 R9
      '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,8'hAA,8'h55, 1'b1,1'b0,8'h55,8'hAA}, // R9
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'hFF,8'h00, 1'b0,1'b0,8'h00,8'hFF}  // R4 R5 R6
   };

   logic         clk = 1'b0;
   logic         rst_n;
   logic         cap_ab_clk, cap_ba_clk;
   logic         sel_ab_stored, sel_ba_stored;
   logic         oe_n, dir_a2b;
   logic [W-1:0] a_in, b_in, a_out, b_out;
   logic         a_oe, b_oe;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_xcvr_reg #(.WIDTH(W)) u_dut (
      .rst_n         (rst_n),
      .cap_ab_clk    (cap_ab_clk),
      .cap_ba_clk    (cap_ba_clk),
      .sel_ab_stored (sel_ab_stored),
      .sel_ba_stored (sel_ba_stored),
      .oe_n          (oe_n),
      .dir_a2b       (dir_a2b),
      .a_in          (a_in),
      .a_out         (a_out),
      .a_oe          (a_oe),
      .b_in          (b_in),
      .b_out         (b_out),
      .b_oe          (b_oe)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse(input bit do_ab, input bit do_ba);
      #(CLK_PERIOD/2);
      cap_ab_clk = do_ab;
      cap_ba_clk = do_ba;
      #(CLK_PERIOD/2);
      cap_ab_clk = 1'b0;
      cap_ba_clk = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (!done && cycles > WATCHDOG) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      cap_ab_clk = 1'b0; cap_ba_clk = 1'b0;
      sel_ab_stored = 1'b1; sel_ba_stored = 1'b1;
      oe_n = 1'b1; dir_a2b = 1'b0;
      a_in = 8'hA5; b_in = 8'h5A;
      #(3*CLK_PERIOD);
      // R1: reset state, stored source selected
      check("R1 b_out after reset", b_out, 8'h00);
      check("R1 a_out after reset", a_out, 8'h00);
      check("R6 oe during reset", {6'd0, a_oe, b_oe}, 8'h00);
      rst_n = 1'b1;
      #(CLK_PERIOD);

      for (int i = 0; i < NVEC; i++) begin
         oe_n = VECS[i].oe_n;
         dir_a2b = VECS[i].dir;
         sel_ab_stored = VECS[i].sab;
         sel_ba_stored = VECS[i].sba;
         a_in = VECS[i].a;
         b_in = VECS[i].b;
         pulse(VECS[i].cap_ab, VECS[i].cap_ba);
         #(CLK_PERIOD/2);
         check($sformatf("R6/R7 a_oe vec%0d", i), {7'd0, a_oe}, {7'd0, VECS[i].x_aoe});
         check($sformatf("R6/R7 b_oe vec%0d", i), {7'd0, b_oe}, {7'd0, VECS[i].x_boe});
         check($sformatf("R5/R3 a_out vec%0d", i), a_out, VECS[i].x_aout);
         check($sformatf("R4/R2 b_out vec%0d", i), b_out, VECS[i].x_bout);
         check($sformatf("R8 vec%0d", i), {7'd0, a_oe & b_oe}, 8'h00);
      end

      // R4 R5: live path follows input change with no capture edge
      sel_ab_stored = 1'b0; sel_ba_stored = 1'b0;
      a_in = 8'h81; b_in = 8'h18;
      #(CLK_PERIOD/2);
      check("R4 live follow", b_out, 8'h81);
      check("R5 live follow", a_out, 8'h18);

      // R2 R3: registers hold between edges (last stored AA / 55)
      sel_ab_stored = 1'b1; sel_ba_stored = 1'b1;
      #(CLK_PERIOD/2);
      check("R2 hold", b_out, 8'hAA);
      check("R3 hold", a_out, 8'h55);

      // R9: capture during isolation, all-ones and all-zeros patterns
      oe_n = 1'b1;
      a_in = 8'hFF; b_in = 8'h00;
      pulse(1'b1, 1'b0);
      #(CLK_PERIOD/2);
      check("R9 ab captured isolated", b_out, 8'hFF);
      check("R9 ba untouched", a_out, 8'h55);

      // R1: asynchronous reset between capture edges
      #(CLK_PERIOD/4);
      rst_n = 1'b0;
      #(CLK_PERIOD/4);
      check("R1 async clear ab", b_out, 8'h00);
      check("R1 async clear ba", a_out, 8'h00);
      rst_n = 1'b1;
      #(CLK_PERIOD);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule